// File: doc/BRIEF.md
# Prescaled Down-Counting Timer with Breakpoint Halt Modes

The block is a down-counter whose steps come from a prescaler. The prescaler counts down once per clock. Each time it passes zero it reloads from a divide-down value and releases one counter step, so the counter steps every (divide-down + 1) clocks. The counter counts from a period value down to zero. On the next step after reaching zero, it wraps back to the period value. Each arrival at zero raises a one-cycle zero event. That event sets a sticky flag, which software clears by writing one to it. When the interrupt enable is set, the same event also raises a level interrupt request.

A debug-halt input models a breakpoint. Two control bits select what the timer does while the input is high. In hard mode the timer freezes after its next counter step. In soft mode it keeps running until it has counted down to zero, so the flag and interrupt still occur, and then it freezes. In free mode it ignores the halt. When the halt input falls, counting resumes from the held value. A control bit also stops the timer outright. Another bit reloads the counter and the prescaler on demand.

Software reaches all of this through a flat word-wide port with a write strobe, an address and a combinational read.

Top module: `halt_timer`

## Requirements
- R1: The prescaler counts down by one per clock. When it is 0 it reloads from the divide-down register (address 2) and the counter steps once, so the count read at addresses 4 (low half) and 5 (high half) changes every divide+1 clocks. The live prescaler value reads at address 6.
- R2: The counter steps from a nonzero value to value−1. From 0 it steps to the period (address 0 low half, address 1 high half). A step that lands on 0 is the zero event.
- R3: The control word sits at address 3. Its bit 15 is a flag that the zero event sets. Writing 1 to bit 15 clears the flag, and writing 0 leaves it unchanged. A zero event in the same cycle as a clearing write leaves the flag set.
- R4: The irq output goes high one cycle after a zero event that occurs while the enable (bit 14) is 1, and nothing else raises it. It falls on a control write that either clears the flag or writes 0 to bit 14.
- R5: Writing control bit 5 as 1 loads the counter from the period and the prescaler from the divide-down value. Bit 5 always reads 0.
- R6: Control bit 4 set to 1 stops the counter and the prescaler, and 0 lets them run. Reset leaves it 0, so counting starts right after reset.
- R7: With bit 11 = 0 and bit 10 = 0 (hard mode), a high debug_halt lets one more counter step happen, and the timer then holds.
- R8: With bit 11 = 0 and bit 10 = 1 (soft mode), a high debug_halt lets counting go on until the step that lands on 0, so the flag and irq are raised, and the timer then holds at 0.
- R9: With bit 11 = 1 (free mode), debug_halt has no effect whatever bit 10 holds.
- R10: When debug_halt falls, counting resumes on the next clock from the held value, without a reload.
- R11: Reset values are: period 0xFFFFFFFF, count 0xFFFFFFFF, divide 0, prescaler 0, control 0. In the control word, bits 13:12 read 0, and bits 9:6 and 3:0 are stored and read back. Address 7 reads 0. Writes to addresses 4–7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| debug_halt | input | 1 | Breakpoint indication |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
A wrong prescaler or counter state shows at address 4 or 6 in the same cycle. It then shifts every later zero event, so flag and irq timing drift within one period. A wrong halt state shows as a count that keeps moving, or that stays still, one step after debug_halt changes. A lost flag set, or a spurious one, shows at the next read of address 3 and on irq one cycle after the zero event. The bench therefore compares every port against a model on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    HM_HARD = 2'd0,
    HM_SOFT = 2'd1,
    HM_FREE = 2'd2
  } halt_mode_e;

  typedef enum logic [2:0] {
    RA_PRD_LO = 3'd0,
    RA_PRD_HI = 3'd1,
    RA_DIV    = 3'd2,
    RA_CTRL   = 3'd3,
    RA_CNT_LO = 3'd4,
    RA_CNT_HI = 3'd5,
    RA_PSC    = 3'd6,
    RA_NONE   = 3'd7
  } reg_addr_e;

  localparam int CB_FLAG   = 15;
  localparam int CB_IE     = 14;
  localparam int CB_FREE   = 11;
  localparam int CB_SOFT   = 10;
  localparam int CB_RELOAD = 5;
  localparam int CB_STOP   = 4;

  // bits of the control word held in plain storage (flag kept apart, 13:12 and 5 excluded)
  localparam logic [15:0] CTRL_KEEP = 16'h4FDF;

  function automatic halt_mode_e mode_of(input logic free_bit, input logic soft_bit);
    if (free_bit)      return HM_FREE;
    else if (soft_bit) return HM_SOFT;
    else               return HM_HARD;
  endfunction

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [PSC_W-1:0] div,
  output logic             tick,
  output logic [PSC_W-1:0] psc
);

  function automatic logic [PSC_W-1:0] psc_next(input logic [PSC_W-1:0] cur,
                                                input logic [PSC_W-1:0] dv);
    return (cur == '0) ? dv : cur - 1'b1;
  endfunction

  assign tick = run && !load && (psc == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    psc <= '0;
    else if (load) psc <= div;
    else if (run)  psc <= psc_next(psc, div);
  end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             zero_evt
);

  function automatic logic [CNT_W-1:0] cnt_step(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] per);
    return (cur == '0) ? per : cur - 1'b1;
  endfunction

  logic [CNT_W-1:0] nxt;
  assign nxt      = cnt_step(cnt, period);
  assign zero_evt = tick && (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '1;
    else if (load) cnt <= period;
    else if (tick) cnt <= nxt;
  end

endmodule

// File: rtl/tmr_halt.sv
module tmr_halt
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       debug_halt,
  input  halt_mode_e mode,
  input  logic       tick,
  input  logic       zero_evt,
  output logic       halt_req,
  output logic       frozen,
  output logic       hold
);

  assign halt_req = debug_halt && (mode != HM_FREE);
  assign hold     = frozen && halt_req;

  always_ff @(posedge clk) begin
    if (!rst_n)         frozen <= 1'b0;
    else if (!halt_req) frozen <= 1'b0;
    else if (!frozen)   frozen <= tick && ((mode == HM_HARD) || zero_evt);
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [2*DW-1:0] cnt,
  input  logic [DW-1:0]   psc,
  input  logic            zero_evt,
  output logic [2*DW-1:0] period,
  output logic [DW-1:0]   div,
  output logic            ie,
  output logic            free_bit,
  output logic            soft_bit,
  output logic            stop,
  output logic            flag,
  output logic            irq,
  output logic            reload_wr
);

  logic [15:0] ctrl_q;
  logic        we_ctrl, clr_wr;

  assign we_ctrl   = bus_we && (bus_addr == RA_CTRL);
  assign reload_wr = we_ctrl && bus_wdata[CB_RELOAD];
  assign clr_wr    = we_ctrl && bus_wdata[CB_FLAG];

  assign ie       = ctrl_q[CB_IE];
  assign free_bit = ctrl_q[CB_FREE];
  assign soft_bit = ctrl_q[CB_SOFT];
  assign stop     = ctrl_q[CB_STOP];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= '1;
      div    <= '0;
      ctrl_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        RA_PRD_LO: period[DW-1:0]    <= bus_wdata;
        RA_PRD_HI: period[2*DW-1:DW] <= bus_wdata;
        RA_DIV:    div               <= bus_wdata;
        RA_CTRL:   ctrl_q            <= bus_wdata[15:0] & CTRL_KEEP;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (zero_evt) flag <= 1'b1;
    else if (clr_wr)   flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (zero_evt && ie)    irq <= 1'b1;
    else if (clr_wr || (we_ctrl && !bus_wdata[CB_IE])) irq <= 1'b0;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_PRD_LO: bus_rdata = period[DW-1:0];
      RA_PRD_HI: bus_rdata = period[2*DW-1:DW];
      RA_DIV:    bus_rdata = div;
      RA_CTRL: begin
        bus_rdata[15:0]    = ctrl_q;
        bus_rdata[CB_FLAG] = flag;
      end
      RA_CNT_LO: bus_rdata = cnt[DW-1:0];
      RA_CNT_HI: bus_rdata = cnt[2*DW-1:DW];
      RA_PSC:    bus_rdata = psc;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/halt_timer.sv
module halt_timer
  import tmr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          debug_halt,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);

  localparam int CNT_W = 2 * DW;
  localparam int PSC_W = DW;

  logic [CNT_W-1:0] cnt, period;
  logic [PSC_W-1:0] psc, div;
  logic             tick, zero_evt, run, reload_wr;
  logic             ie, free_bit, soft_bit, stop, flag;
  logic             halt_req, frozen, hold;
  halt_mode_e       mode;

  assign mode = mode_of(free_bit, soft_bit);
  assign run  = !stop && !hold;

  tmr_regs #(.DW(DW), .AW(3)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .psc(psc), .zero_evt(zero_evt),
    .period(period), .div(div), .ie(ie), .free_bit(free_bit), .soft_bit(soft_bit),
    .stop(stop), .flag(flag), .irq(irq), .reload_wr(reload_wr)
  );

  tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run(run), .load(reload_wr),
    .div(div), .tick(tick), .psc(psc)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(reload_wr),
    .period(period), .cnt(cnt), .zero_evt(zero_evt)
  );

  tmr_halt u_halt (
    .clk(clk), .rst_n(rst_n), .debug_halt(debug_halt), .mode(mode),
    .tick(tick), .zero_evt(zero_evt),
    .halt_req(halt_req), .frozen(frozen), .hold(hold)
  );

endmodule

// File: rtl/halt_timer_chk.sv
module halt_timer_chk #(
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [2:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            zero_evt,
  input logic            reload_wr,
  input logic            hold,
  input logic            frozen,
  input logic            stop,
  input logic            free_bit,
  input logic            soft_bit,
  input logic            ie,
  input logic            flag,
  input logic            irq,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] period,
  input logic [DW-1:0]   psc,
  input logic [DW-1:0]   div
);

  p_zero_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (cnt == '0));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> flag);

  p_flag_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(bus_we && bus_addr == 3'd3 && bus_wdata[15])) |=> flag);

  p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(zero_evt && ie));

  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_wr |=> (cnt == $past(period) && psc == $past(div)));

  p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !reload_wr) |=> ($stable(cnt) && $stable(psc)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !reload_wr) |=> $stable(cnt));

  p_soft_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(frozen) && $past(soft_bit && !free_bit)) |-> flag);

  p_free_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (free_bit && $past(free_bit)) |-> !frozen);

endmodule

bind halt_timer halt_timer_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .zero_evt(zero_evt), .reload_wr(reload_wr), .hold(hold), .frozen(frozen),
  .stop(stop), .free_bit(free_bit), .soft_bit(soft_bit), .ie(ie), .flag(flag),
  .irq(irq), .cnt(cnt), .period(period), .psc(psc), .div(div)
);

// File: tb/test_halt_timer.sv
module test_halt_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        debug_halt = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = 3'd4;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  always #10 clk = ~clk;

  halt_timer #(.DW(16)) i_halt_timer (
    .clk(clk), .rst_n(rst_n), .debug_halt(debug_halt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  // behavioural reference state
  bit [31:0] m_cnt, m_per;
  bit [15:0] m_div, m_psc;
  bit        m_flag, m_irq, m_ie, m_free, m_soft, m_stop, m_frz;
  bit [3:0]  m_r96, m_r30;

  always @(posedge clk) begin : model
    bit hreq, run, rl, tk, zr, ctl_wr;
    bit [31:0] ncnt;
    bit [15:0] npsc;
    if (!rst_n) begin
      m_cnt = 32'hFFFF_FFFF; m_per = 32'hFFFF_FFFF; m_div = 0; m_psc = 0;
      {m_flag, m_irq, m_ie, m_free, m_soft, m_stop, m_frz} = '0;
      m_r96 = 0; m_r30 = 0;
    end else begin
      ctl_wr = bus_we && bus_addr == 3;
      hreq = debug_halt && !m_free;
      run  = !m_stop && !(m_frz && hreq);
      rl   = ctl_wr && bus_wdata[5];
      tk   = run && m_psc == 0 && !rl;
      zr = 0; ncnt = m_cnt; npsc = m_psc;
      if (rl) begin
        ncnt = m_per; npsc = m_div;
      end else if (run) begin
        if (m_psc == 0) begin
          npsc = m_div;
          ncnt = (m_cnt == 0) ? m_per : m_cnt - 1;
          zr = (ncnt == 0);
        end else npsc = m_psc - 1;
      end
      if (!hreq) m_frz = 0;
      else if (!m_frz) m_frz = tk && (!m_soft || zr);
      if (zr && m_ie) m_irq = 1;
      else if (ctl_wr && (bus_wdata[15] || !bus_wdata[14])) m_irq = 0;
      if (zr) m_flag = 1;
      else if (ctl_wr && bus_wdata[15]) m_flag = 0;
      if (bus_we) begin
        case (bus_addr)
          3'd0: m_per[15:0] = bus_wdata;
          3'd1: m_per[31:16] = bus_wdata;
          3'd2: m_div = bus_wdata;
          3'd3: begin
            m_ie = bus_wdata[14]; m_free = bus_wdata[11]; m_soft = bus_wdata[10];
            m_r96 = bus_wdata[9:6]; m_stop = bus_wdata[4]; m_r30 = bus_wdata[3:0];
          end
          default: ;
        endcase
      end
      m_cnt = ncnt; m_psc = npsc;
    end
  end

  function automatic bit [15:0] m_read(input bit [2:0] a);
    case (a)
      3'd0: return m_per[15:0];
      3'd1: return m_per[31:16];
      3'd2: return m_div;
      3'd3: return {m_flag, m_ie, 2'b00, m_free, m_soft, m_r96, 1'b0, m_stop, m_r30};
      3'd4: return m_cnt[15:0];
      3'd5: return m_cnt[31:16];
      3'd6: return m_psc;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic string tag_of(input bit [2:0] a);
    case (a)
      3'd3: return "R3 control word";
      3'd4, 3'd5: return "R2 count";
      3'd6: return "R1 prescaler";
      default: return "R11 register read";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk(tag_of(bus_addr), {16'h0, bus_rdata}, {16'h0, m_read(bus_addr)});
      chk("R4 irq level", {31'h0, irq}, {31'h0, m_irq});
    end
  end

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic wr(input bit [2:0] a, input bit [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_we = 1'b0; bus_addr = 3'd4; bus_wdata = '0;
  endtask

  task automatic expect_rd(input bit [2:0] a, input bit [15:0] exp, input string tag);
    bus_addr = a;
    @(negedge clk);
    chk(tag, {16'h0, bus_rdata}, {16'h0, exp});
    step();
    bus_addr = 3'd4;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog: actual still running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(2);
    cmp_on = 1'b1;
    // R11 / R6 reset values
    expect_rd(3, 16'h0000, "R6 reset control word");
    expect_rd(5, 16'hFFFF, "R11 reset count high");
    expect_rd(1, 16'hFFFF, "R11 reset period high");
    expect_rd(2, 16'h0000, "R11 reset divide");
    rst_n = 1'b1;
    step(3);
    // R5 reload and R1 prescale: period 5, divide 2
    wr(0, 16'd5); wr(1, 16'd0); wr(2, 16'd2);
    wr(3, 16'h0020);
    expect_rd(6, 16'd2, "R5 prescaler loaded");
    expect_rd(4, 16'd5, "R1 count held while prescaling");
    expect_rd(4, 16'd5, "R1 count held second clock");
    expect_rd(4, 16'd4, "R1 step after divide+1 clocks");
    expect_rd(3, 16'h0000, "R5 reload bit reads 0");
    // R2/R3/R4 with interrupt disabled
    step(20);
    expect_rd(3, 16'h8000, "R3 flag set by zero");
    chk("R4 irq stays low when disabled", {31'h0, irq}, 32'h0);
    wr(3, 16'h4000);
    expect_rd(3, 16'hC000, "R3 writing 0 keeps flag");
    chk("R4 enabling alone raises nothing", {31'h0, irq}, 32'h0);
    step(25);
    chk("R4 irq on zero while enabled", {31'h0, irq}, 32'h1);
    // R6 stop
    wr(3, 16'h4010);
    bus_addr = 3'd4;
    step(5);
    expect_rd(4, m_read(4), "R6 count frozen while stopped");
    wr(3, 16'hC010);
    expect_rd(3, 16'h4010, "R3 write-1 clears flag");
    chk("R4 irq cleared with flag", {31'h0, irq}, 32'h0);
    // R3 set beats clear in the same cycle
    wr(0, 16'd3); wr(2, 16'd0);
    wr(3, 16'h4020);
    step(2);
    wr(3, 16'hC000);
    expect_rd(3, 16'hC000, "R3 zero event beats clear");
    chk("R4 irq set beats clear", {31'h0, irq}, 32'h1);
    // R11 reserved bits
    wr(3, 16'h33DF);
    expect_rd(3, 16'h83DF, "R11 reserved readback");
    wr(4, 16'h1234);
    expect_rd(4, m_read(4), "R11 count not writable");
    wr(3, 16'h8000);
    // R7 hard stop, R10 resume
    wr(0, 16'd100); wr(1, 16'd0); wr(2, 16'd0);
    wr(3, 16'h0020);
    debug_halt = 1'b1;
    step(6);
    expect_rd(4, 16'd99, "R7 hard stop after one step");
    debug_halt = 1'b0;
    step();
    expect_rd(4, 16'd98, "R10 resume without reload");
    // R8 soft stop
    wr(0, 16'd3);
    wr(3, 16'hC420);
    debug_halt = 1'b1;
    step(8);
    expect_rd(4, 16'd0, "R8 soft stop holds at zero");
    expect_rd(3, 16'hC400, "R8 flag raised before stop");
    chk("R8 irq raised before stop", {31'h0, irq}, 32'h1);
    debug_halt = 1'b0;
    step(2);
    // R9 free run
    wr(0, 16'd100);
    wr(3, 16'h8C20);
    debug_halt = 1'b1;
    step(10);
    expect_rd(4, 16'd90, "R9 free run ignores halt");
    debug_halt = 1'b0;
    step(4);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule